// File: doc/BRIEF.md
# Page Protection Permission Checker

This block decides whether one memory access may proceed under a hashed-page-table memory management scheme. For each request it takes the segment attributes, the current privilege level, the protection fields of the matching page entry, the kind of access (load, store or instruction fetch) and a selector for 32-bit or 64-bit layout. It works out the protection key and a combined no-execute condition. From these it forms read, write and execute rights and then returns a verdict.

A request is captured on a clock edge where `req_valid` is high. One cycle later the block presents the verdict on `rsp_status` and the rights vector on `rsp_rights`, qualified by `rsp_valid`. Hashing, table walking and address formation are handled elsewhere. This block only judges an entry that has already been found.

Top module: `pp_perm_check`

## Requirements
- R1: The protection key is 1 in two cases: the user-state key bit is set while in user mode (`req_user`=1), or the supervisor-state key bit is set while in supervisor mode. In every other case the key is 0. In 32-bit mode the user key bit is `req_seg` bit 29 and the supervisor key bit is bit 30. In 64-bit mode they are bit 6 and bit 7.
- R2: With key 0, the protection code gives these rights:
  - codes 0, 1 and 2 give read and write;
  - codes 3 and 6 give read only;
  - codes 4, 5 and 7 give nothing.
- R3: With key 1, the protection code gives these rights:
  - code 2 gives read and write;
  - codes 1 and 3 give read only;
  - codes 0, 4, 5, 6 and 7 give nothing.
- R4: The protection code is formed differently in each mode:
  - In 32-bit mode it is `req_pte` bits 1:0, with a zero third bit.
  - In 64-bit mode it is `req_pte` bits 1:0, with `req_pte` bit 63 as its third bit.
- R5: Execute right (`rsp_rights` bit 0) is 1 only when the combined no-execute flag is 0. Read is bit 2 and write is bit 1.
- R6: The combined no-execute flag is formed as follows:
  - In 32-bit mode it is the segment no-execute bit, `req_seg` bit 28.
  - In 64-bit mode it is the OR of the segment attribute bit 5, entry bit 2 (no-execute) and entry bit 3 (guarded).
  - Entry bits 2 and 3 are ignored in 32-bit mode.
- R7: Access type encoding is 0 for load, 1 for store and 2 for fetch. A load needs read, a store needs write and a fetch needs execute. If the needed right is missing, the status is 1 (protection fault). Otherwise the status is 0 (granted).
- R8: A fetch whose segment no-execute bit is set returns status 2 (segment no-execute fault). This takes precedence over the entry check.
- R9: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. While `rst_n` is low, `rsp_valid`, `rsp_status` and `rsp_rights` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_mode64 | input | 1 | 1 selects the 64-bit field layout |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_seg | input | 32 | Segment register (32-bit) or attribute byte in bits 7:0 (64-bit) |
| req_pte | input | 64 | Second word of the page entry |
| req_acc | input | 2 | 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 2 | 0 granted, 1 protection fault, 2 segment no-execute fault |
| rsp_rights | output | 3 | {read, write, execute} |

## Verification
A fetch can carry a segment no-execute bit while its entry also denies execute. In that case the segment rejection and the entry protection check fall into the same cycle. The bench provokes this by issuing fetches with both conditions set and checks that status 2 wins. It also sends back-to-back requests that alternate modes. This makes the capture of a new request coincide with the output of the previous one, and each response is matched in order against its queued expectation.

// File: rtl/pp_perm_check.sv
module pp_perm_check (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_mode64,
  input  logic        req_user,
  input  logic [31:0] req_seg,
  input  logic [63:0] req_pte,
  input  logic [1:0]  req_acc,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [2:0]  rsp_rights
);

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_PROT  = 2'd1;
  localparam logic [1:0] ST_SEGNX = 2'd2;

  logic       key_usr_bit, key_sup_bit, key;
  logic       seg_nx, nx_all;
  logic [2:0] pp;
  logic       rd, wr, ex;
  logic       need_ok;
  logic [1:0] status_n;

  assign key_usr_bit = req_mode64 ? req_seg[6] : req_seg[29];
  assign key_sup_bit = req_mode64 ? req_seg[7] : req_seg[30];
  assign key = (key_usr_bit & req_user) | (key_sup_bit & ~req_user);

  assign seg_nx = req_mode64 ? req_seg[5] : req_seg[28];
  assign nx_all = seg_nx | (req_mode64 & (req_pte[2] | req_pte[3]));

  assign pp = {req_mode64 & req_pte[63], req_pte[1:0]};

  always_comb begin
    rd = 1'b0;
    wr = 1'b0;
    if (!key) begin
      case (pp)
        3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
        3'd3, 3'd6:       rd = 1'b1;
        default:          ;
      endcase
    end else begin
      case (pp)
        3'd2:       begin rd = 1'b1; wr = 1'b1; end
        3'd1, 3'd3: rd = 1'b1;
        default:    ;
      endcase
    end
  end

  assign ex = ~nx_all;

  always_comb begin
    case (req_acc)
      ACC_LOAD:  need_ok = rd;
      ACC_STORE: need_ok = wr;
      ACC_FETCH: need_ok = ex;
      default:   need_ok = 1'b0;
    endcase
  end

  assign status_n = (req_acc == ACC_FETCH && seg_nx) ? ST_SEGNX :
                    need_ok ? ST_OK : ST_PROT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_rights <= 3'b000;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= status_n;
        rsp_rights <= {rd, wr, ex};
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_SEGNX_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == ACC_FETCH && seg_nx) |=> (rsp_status == ST_SEGNX)); // R8
  AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!rsp_rights[1] || rsp_rights[2])); // R2
  AST_GRANT_HAS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_OK) |-> ($countones(rsp_rights) != 0)); // R7
  AST_STORE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_acc == ACC_STORE) |=> (rsp_status == ST_OK) == rsp_rights[1]); // R7
  AST_NX_CLEARS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg_nx) |=> !rsp_rights[0]); // R5

endmodule

// File: tb/pp_perm_check_bench.sv
module pp_perm_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_mode64 = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] req_seg = '0;
  logic [63:0] req_pte = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [2:0]  rsp_rights;

  int checks = 0;
  int errors = 0;
  logic [4:0]  exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #10 clk = ~clk;

  pp_perm_check u_pp_perm_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode64(req_mode64),
    .req_user(req_user), .req_seg(req_seg), .req_pte(req_pte), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rights(rsp_rights));

  function automatic logic [4:0] model(input logic m64, input logic usr,
      input logic [31:0] seg, input logic [63:0] pte, input logic [1:0] acc);
    logic k, snx, nx, r, w, x, ok;
    logic [2:0] pp;
    logic [1:0] st;
    k   = m64 ? ((seg[6] && usr) || (seg[7] && !usr)) : ((seg[29] && usr) || (seg[30] && !usr));
    snx = m64 ? seg[5] : seg[28];
    nx  = snx || (m64 && (pte[2] || pte[3]));
    pp  = m64 ? {pte[63], pte[1:0]} : {1'b0, pte[1:0]};
    if (k == 0) begin
      r = (pp <= 3) || pp == 6;
      w = pp <= 2;
    end else begin
      r = pp == 1 || pp == 2 || pp == 3;
      w = pp == 2;
    end
    x  = !nx;
    ok = (acc == 0) ? r : (acc == 1) ? w : (acc == 2) ? x : 1'b0;
    st = (acc == 2 && snx) ? 2'd2 : (ok ? 2'd0 : 2'd1);
    return {st, r, w, x};
  endfunction

  task automatic send(input logic m64, input logic usr, input logic [31:0] seg,
      input logic [63:0] pte, input logic [1:0] acc, input string tag);
    req_valid = 1; req_mode64 = m64; req_user = usr; req_seg = seg;
    req_pte = pte; req_acc = acc;
    exp_q.push_back(model(m64, usr, seg, pte, acc));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got status=%0d rights=%b expected status=%0d rights=%b",
               tag, act[4:3], act[2:0], exp[4:3], exp[2:0]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk({rsp_status, rsp_rights}, 5'h1f, "R9 unexpected response");
      end else begin
        chk({rsp_status, rsp_rights}, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({rsp_valid, rsp_status, rsp_rights} == 6'd0 ? 5'd0 : 5'd1, 5'd0, "R9 reset state");
    rst_n = 1;
    @(posedge clk); #1;
    // R2 key 0 (supervisor, no sup key bit), all pp, 32-bit loads and stores
    for (int p = 0; p < 4; p++) begin
      send(0, 0, 32'h0, 64'(p), 2'd0, "R2 key0 load");
      send(0, 0, 32'h0, 64'(p), 2'd1, "R2 key0 store");
    end
    // R1 R3 key 1 via user key bit in user mode
    for (int p = 0; p < 4; p++) begin
      send(0, 1, 32'h2000_0000, 64'(p), 2'd1, "R3 key1 store");
      send(0, 1, 32'h2000_0000, 64'(p), 2'd0, "R1 user key load");
    end
    // R1 key bit for wrong mode has no effect
    send(0, 0, 32'h2000_0000, 64'd0, 2'd1, "R1 user bit in supervisor");
    send(0, 0, 32'h4000_0000, 64'd0, 2'd1, "R1 sup key store");
    // R4 64-bit pp with bit 63, both keys
    for (int p = 0; p < 8; p++) begin
      send(1, 0, 32'h0,  {p[2], 60'd0, 1'b0, p[1:0]}, 2'd0, "R4 key0 pp64 load");
      send(1, 1, 32'h40, {p[2], 60'd0, 1'b0, p[1:0]}, 2'd0, "R4 key1 pp64 load");
      send(1, 1, 32'h40, {p[2], 60'd0, 1'b0, p[1:0]}, 2'd1, "R3 key1 pp64 store");
    end
    // R4 bit 63 ignored in 32-bit mode
    send(0, 0, 32'h0, 64'h8000_0000_0000_0002, 2'd1, "R4 bit63 ignored 32b");
    // R5 R6 exec rights
    send(1, 0, 32'h0, 64'h4, 2'd2, "R6 entry noexec fetch");
    send(1, 0, 32'h0, 64'h8, 2'd2, "R6 guarded fetch");
    send(1, 0, 32'h0, 64'h0, 2'd2, "R5 fetch granted");
    send(0, 0, 32'h0, 64'hC, 2'd2, "R6 entry bits ignored 32b");
    send(0, 0, 32'h0, 64'h3, 2'd2, "R5 fetch ignores pp");
    // R8 segment no-execute fetch, with entry also denying
    send(0, 0, 32'h1000_0000, 64'h0, 2'd2, "R8 seg nx 32b");
    send(1, 1, 32'h60, 64'hC, 2'd2, "R8 seg nx and entry nx 64b");
    send(0, 0, 32'h1000_0000, 64'h0, 2'd0, "R7 seg nx load ok");
    // R7 access type 3
    send(0, 0, 32'h0, 64'h0, 2'd3, "R7 reserved access");
    // R9 gap then back-to-back
    @(posedge clk); #1;
    @(posedge clk); #1;
    for (int i = 0; i < 16; i++) begin
      send(i[0], i[1], {1'b0, i[2], i[3], i[0], 20'd0, 1'b0, i[3], i[1], 5'd0},
           {i[3], 59'd0, i[2], 1'b0, i[1], i[0]}, 2'(i % 3), "R7 mixed stream");
    end
    repeat (4) @(posedge clk);
    #1;
    if (exp_q.size() != 0) chk(5'd1, 5'd0, "R9 missing responses");
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule